// File: doc/BRIEF.md
# Shift-Register Raster Timing Generator

This block produces the horizontal sync, vertical sync, display-enable and start-of-frame strobes for a raster display, all from one pixel clock. It has no binary counters. Each axis keeps its position in a 16-bit maximal-length shift register that is reset to all ones. On every step the register moves one place toward the top bit, and the feedback bit is the XOR of a fixed set of taps. A next-state function of this kind has only one level of logic, so it stays shallow at any line width.

Because of this, every threshold is given as the shift-register state that the counter holds after the wanted number of steps from all ones. It is not given as a plain count. Software, or a helper close to the block, converts each count once. The block then only compares the live state for equality with each programmed word. Both axes place their origin at the start of sync. The horizontal counter steps on every clock. The vertical counter steps once per line, in the clock where the horizontal counter wraps.

Top module: `vtg_top`

## Requirements
- R1: While `rst` is high on a clock edge, both position registers load all ones (position 0) and `hsync`, `vsync`, `de` and `sof` go low. After `rst` falls, the first clock has both axes at position 0 with all four outputs low.
- R2: A position register steps by shifting left one place. The new bit 0 is the XOR of bits 15, 4, 2 and 1 of the old state (tap mask 16'h8016). A word for position n is therefore the state after n such steps from 16'hFFFF.
- R3: When the horizontal state equals `h_line_end`, programmed as the word for n, it reloads all ones on the next clock. A line therefore lasts n+1 clocks.
- R4: The vertical state steps only in a clock where the horizontal state wraps. It reloads all ones when it also equals `v_frame_end` (the word for m), so a frame lasts m+1 lines.
- R5: `hsync` is high, active high, exactly while the horizontal position p satisfies s < p <= e, where `h_sync_start` and `h_sync_end` are the words for s and e.
- R6: `vsync` is high exactly while the line number q satisfies s < q <= e, for the words in `v_sync_start` and `v_sync_end`. It changes only on the first clock of a line.
- R7: `de` is high exactly when the horizontal position lies in (`h_disp_start`, `h_disp_end`] and the line lies in (`v_disp_start`, `v_disp_end`], with each bound given as a word.
- R8: `sof` is high for exactly one clock, the clock at position 0 of line 0 that follows a frame wrap. It is not raised for the position 0 that comes straight out of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| h_disp_start | input | 16 | Word for the horizontal position after which display opens |
| h_disp_end | input | 16 | Word for the last horizontal display position |
| h_line_end | input | 16 | Word for the last position of a line |
| h_sync_start | input | 16 | Word for the horizontal position after which sync rises |
| h_sync_end | input | 16 | Word for the last horizontal sync position |
| v_disp_start | input | 16 | Word for the line after which display opens |
| v_disp_end | input | 16 | Word for the last display line |
| v_frame_end | input | 16 | Word for the last line of a frame |
| v_sync_start | input | 16 | Word for the line after which vertical sync rises |
| v_sync_end | input | 16 | Word for the last vertical sync line |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| de | output | 1 | Display enable |
| sof | output | 1 | One-clock start-of-frame strobe |

## Verification
All four outputs are registers. Each one shows, in a given clock, the values that belong to the axis positions the counters hold in that same clock. The bench therefore keeps an integer position per axis. It advances these positions by the requirement rules at every rising edge and compares all outputs at the following falling edge, with no extra lag to allow for. A change to `vsync` or to the vertical part of `de` is due in the first clock of the next line, at the edge where the horizontal position wraps. `sof` is due in the first clock of each frame after the first. The line period and the frame period are measured separately, from `hsync` rising edges and from the gap between `sof` pulses.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
  localparam int unsigned VTG_W = 16;
  typedef logic [VTG_W-1:0] vtg_word_t;
  localparam vtg_word_t VTG_ORIGIN = '1;

  // one shift step: left by one, feedback is parity of the tapped bits
  function automatic vtg_word_t vtg_step(vtg_word_t s, vtg_word_t taps);
    return {s[VTG_W-2:0], ^(s & taps)};
  endfunction
endpackage

// File: rtl/vtg_lfsr_counter.sv
module vtg_lfsr_counter
  import vtg_pkg::*;
#(
  parameter vtg_word_t TAPS = 16'h8016
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      adv,
  input  vtg_word_t last_word,
  output vtg_word_t state,
  output logic      at_last
);
  assign at_last = (state == last_word);

  always_ff @(posedge clk) begin
    if (rst)
      state <= VTG_ORIGIN;
    else if (adv)
      state <= at_last ? VTG_ORIGIN : vtg_step(state, TAPS);
  end
endmodule

// File: rtl/vtg_window.sv
module vtg_window
  import vtg_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      en,
  input  vtg_word_t cur,
  input  vtg_word_t open_word,
  input  vtg_word_t close_word,
  output logic      flag,
  output logic      flag_nxt
);
  always_comb begin
    flag_nxt = flag;
    if (en) begin
      if (cur == open_word)
        flag_nxt = 1'b1;
      else if (cur == close_word)
        flag_nxt = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) flag <= 1'b0;
    else     flag <= flag_nxt;
  end
endmodule

// File: rtl/vtg_top.sv
module vtg_top
  import vtg_pkg::*;
#(
  parameter vtg_word_t TAPS = 16'h8016,
  parameter int unsigned NUM_WIN = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [VTG_W-1:0]     h_disp_start,
  input  logic [VTG_W-1:0]     h_disp_end,
  input  logic [VTG_W-1:0]     h_line_end,
  input  logic [VTG_W-1:0]     h_sync_start,
  input  logic [VTG_W-1:0]     h_sync_end,
  input  logic [VTG_W-1:0]     v_disp_start,
  input  logic [VTG_W-1:0]     v_disp_end,
  input  logic [VTG_W-1:0]     v_frame_end,
  input  logic [VTG_W-1:0]     v_sync_start,
  input  logic [VTG_W-1:0]     v_sync_end,
  output logic                 hsync,
  output logic                 vsync,
  output logic                 de,
  output logic                 sof
);
  // window slots: 0 h display, 1 h sync, 2 v display, 3 v sync
  localparam int unsigned W_HDE = 0;
  localparam int unsigned W_HS  = 1;
  localparam int unsigned W_VDE = 2;
  localparam int unsigned W_VS  = 3;

  vtg_word_t h_state, v_state;
  logic      h_wrap, v_last;

  vtg_lfsr_counter #(.TAPS(TAPS)) u_hcnt (
    .clk(clk), .rst(rst), .adv(1'b1), .last_word(h_line_end),
    .state(h_state), .at_last(h_wrap)
  );

  vtg_lfsr_counter #(.TAPS(TAPS)) u_vcnt (
    .clk(clk), .rst(rst), .adv(h_wrap), .last_word(v_frame_end),
    .state(v_state), .at_last(v_last)
  );

  vtg_word_t win_open  [NUM_WIN];
  vtg_word_t win_close [NUM_WIN];
  logic [NUM_WIN-1:0] win_flag, win_nxt;

  assign win_open[W_HDE]  = h_disp_start;
  assign win_close[W_HDE] = h_disp_end;
  assign win_open[W_HS]   = h_sync_start;
  assign win_close[W_HS]  = h_sync_end;
  assign win_open[W_VDE]  = v_disp_start;
  assign win_close[W_VDE] = v_disp_end;
  assign win_open[W_VS]   = v_sync_start;
  assign win_close[W_VS]  = v_sync_end;

  for (genvar gi = 0; gi < NUM_WIN; gi++) begin : g_win
    localparam bit IS_VERT = (gi >= 2);
    if (IS_VERT) begin : g_v
      vtg_window u_win (
        .clk(clk), .rst(rst), .en(h_wrap), .cur(v_state),
        .open_word(win_open[gi]), .close_word(win_close[gi]),
        .flag(win_flag[gi]), .flag_nxt(win_nxt[gi])
      );
    end else begin : g_h
      vtg_window u_win (
        .clk(clk), .rst(rst), .en(1'b1), .cur(h_state),
        .open_word(win_open[gi]), .close_word(win_close[gi]),
        .flag(win_flag[gi]), .flag_nxt(win_nxt[gi])
      );
    end
  end

  assign hsync = win_flag[W_HS];
  assign vsync = win_flag[W_VS];

  always_ff @(posedge clk) begin
    if (rst) begin
      de  <= 1'b0;
      sof <= 1'b0;
    end else begin
      de  <= win_nxt[W_HDE] & win_nxt[W_VDE];
      sof <= h_wrap & v_last;
    end
  end
endmodule

// File: rtl/vtg_checker.sv
module vtg_checker
  import vtg_pkg::*;
#(
  parameter vtg_word_t TAPS = 16'h8016
) (
  input logic      clk,
  input logic      rst,
  input vtg_word_t h_state,
  input vtg_word_t v_state,
  input vtg_word_t h_line_end,
  input logic      h_wrap,
  input logic      vsync,
  input logic      sof
);
  logic live;
  always_ff @(posedge clk) begin
    if (rst) live <= 1'b0;
    else     live <= 1'b1;
  end

  assert_h_step_R2: assert property (@(posedge clk) disable iff (rst)
    (live && $past(h_state) != $past(h_line_end))
      |-> h_state == vtg_step($past(h_state), TAPS));

  assert_h_reload_R3: assert property (@(posedge clk) disable iff (rst)
    (live && $past(h_state) == $past(h_line_end)) |-> h_state == VTG_ORIGIN);

  assert_v_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (live && !$past(h_wrap)) |-> $stable(v_state));

  assert_vsync_linestart_R6: assert property (@(posedge clk) disable iff (rst)
    (live && vsync != $past(vsync)) |-> h_state == VTG_ORIGIN);

  assert_sof_origin_R8: assert property (@(posedge clk) disable iff (rst)
    sof |-> (h_state == VTG_ORIGIN && v_state == VTG_ORIGIN));

  assert_sof_single_R8: assert property (@(posedge clk) disable iff (rst)
    sof |=> !sof);
endmodule

bind vtg_top vtg_checker #(.TAPS(TAPS)) u_vtg_checker (
  .clk(clk), .rst(rst), .h_state(h_state), .v_state(v_state),
  .h_line_end(h_line_end), .h_wrap(h_wrap), .vsync(vsync), .sof(sof)
);

// File: tb/vtg_top_tb.sv
module vtg_top_tb;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [15:0] hds, hde, hle, hss, hse, vds, vde, vfe, vss, vse;
  logic hsync, vsync, de, sof;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vtg_top u_dut (
    .clk(clk), .rst(rst),
    .h_disp_start(hds), .h_disp_end(hde), .h_line_end(hle),
    .h_sync_start(hss), .h_sync_end(hse),
    .v_disp_start(vds), .v_disp_end(vde), .v_frame_end(vfe),
    .v_sync_start(vss), .v_sync_end(vse),
    .hsync(hsync), .vsync(vsync), .de(de), .sof(sof)
  );

  // state after n steps from all ones, taps 15,4,2,1 (R2)
  function automatic logic [15:0] word_for(int n);
    logic [15:0] s = 16'hFFFF;
    for (int k = 0; k < n; k++) s = {s[14:0], s[15] ^ s[4] ^ s[2] ^ s[1]};
    return s;
  endfunction

  function automatic bit inside_win(int p, int lo, int hi);
    return (p > lo) && (p <= hi);
  endfunction

  task automatic chk(int act, int exp, string tag);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // one configuration in counts; runs two frames plus a few clocks
  task automatic run_cfg(int htot, int hs_e, int hd_s, int hd_e,
                         int vlast, int vs_e, int vd_s, int vd_e);
    int hc = 0, vc = 0;
    bit first = 1'b1;
    int last_sof = -1, last_hs_rise = -1;
    bit prev_hs = 1'b0;
    int cyc = 0;
    int total = htot * (vlast + 1) * 2 + 7;
    @(negedge clk);
    rst = 1'b1;
    hle = word_for(htot - 1);
    hss = word_for(1);        hse = word_for(hs_e);
    hds = word_for(hd_s);     hde = word_for(hd_e);
    vfe = word_for(vlast);
    vss = word_for(0);        vse = word_for(vs_e);
    vds = word_for(vd_s);     vde = word_for(vd_e);
    repeat (2) @(negedge clk);
    rst = 1'b0;
    // R1: first clock after reset sits at position 0 with quiet outputs
    chk(hsync, 0, "R1 hsync after reset");
    chk(vsync, 0, "R1 vsync after reset");
    chk(de,    0, "R1 de after reset");
    chk(sof,   0, "R1 sof after reset");
    for (int t = 0; t < total; t++) begin
      @(posedge clk);
      if (hc == htot - 1) begin
        hc = 0;
        vc = (vc == vlast) ? 0 : vc + 1;
      end else hc++;
      first = 1'b0;
      cyc++;
      @(negedge clk);
      chk(hsync, inside_win(hc, 1, hs_e), "R5 hsync");
      chk(vsync, inside_win(vc, 0, vs_e), "R6 vsync");
      chk(de, inside_win(hc, hd_s, hd_e) && inside_win(vc, vd_s, vd_e), "R7 de");
      chk(sof, (hc == 0 && vc == 0 && !first), "R8 sof");
      if (hsync && !prev_hs) begin
        // R2 R3: line period follows from the stepped words
        if (last_hs_rise >= 0) chk(cyc - last_hs_rise, htot, "R3 line period");
        last_hs_rise = cyc;
      end
      prev_hs = hsync;
      if (sof) begin
        if (last_sof >= 0) chk(cyc - last_sof, htot * (vlast + 1), "R4 frame period");
        last_sof = cyc;
      end
    end
  endtask

  initial begin
    hds = '0; hde = '0; hle = '0; hss = '0; hse = '0;
    vds = '0; vde = '0; vfe = '0; vss = '0; vse = '0;
    void'($urandom(32'd1357));
    // directed: display closes on the last position of line and frame, 1-clock sync
    run_cfg(20, 2, 5, 19, 6, 1, 2, 6);
    // directed: small raster, wide syncs
    run_cfg(12, 6, 7, 10, 4, 2, 3, 4);
    for (int r = 0; r < 5; r++) begin
      int htot = 24 + int'($urandom_range(0, 24));
      int hw   = 1 + int'($urandom_range(0, 4));
      int hd_s = hw + 2 + int'($urandom_range(0, 3));
      int hd_e = hd_s + 4 + int'($urandom_range(0, htot - hd_s - 5));
      int vlast = 6 + int'($urandom_range(0, 6));
      int vw   = 1 + int'($urandom_range(0, 1));
      int vd_s = vw + 1 + int'($urandom_range(0, 1));
      int vd_e = vd_s + 1 + int'($urandom_range(0, vlast - vd_s - 1));
      run_cfg(htot, hw + 1, hd_s, hd_e, vlast, vw, vd_s, vd_e);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule